// File: doc/BRIEF.md
# Per-ID Response Ordering Checker

This block watches a stream of observed bus requests and responses and checks one property: responses that share a transaction ID must return in the order their requests were made. Responses with different IDs may come back in any interleaving. Each request carries an ID and a short address tag. Each response carries an ID and the tag of the request it claims to finish. The block keeps a small FIFO of pending tags for every ID and compares each response against the oldest pending entry for that ID.

It flags three faults as they happen. A tag mismatch is an ordering error. A response for an ID with nothing pending is an orphan. A request that finds its FIFO full is an overflow. When end-of-test is signalled, the block walks every ID in turn and reports the number of requests still pending. It then gives a single pass/fail verdict on completeness. The block does not look at data. It does not judge handshake legality, and it does not extract tags from bus signals; an upstream monitor supplies the ID/tag pairs.

Top module: `id_order_checker`

## Requirements
- R1: A request pushes its tag at the tail of its ID's FIFO. Responses that return the pending tags of one ID in request order raise no error.
- R2: A response for an ID with pending entries always pops the head of that FIFO. If the response tag differs from the popped head, an ordering-error pulse is raised carrying the response ID.
- R3: A response whose ID has no pending entry raises an orphan pulse carrying that ID. Nothing is popped.
- R4: Ordering is not checked across IDs. A response for one ID may overtake older pending requests of other IDs without error.
- R5: Each of the 4 IDs holds at most 4 pending tags. If a request arrives for a full FIFO that is not popped in the same cycle, an overflow pulse is raised carrying the request ID, and the tag is dropped. If the full FIFO is popped in that same cycle, the request is accepted.
- R6: When a request and a response for the same ID arrive in one cycle, the response is judged against the contents that existed before the push. If that FIFO was empty, the response is an orphan and the request is still stored.
- R7: An end-of-test strobe sampled at a clock edge starts a report on the following edge. The report covers one ID per cycle, ID 0 first. Each report cycle drives a valid flag, the ID, and its pending count. A strobe that arrives while a report is running is ignored.
- R8: The cycle after the last ID is reported, a one-cycle done pulse appears. With it, pass is 1 if every count was zero and 0 otherwise. Pass holds until the next report starts.
- R9: Error outputs are registered. Each is high for exactly the one cycle after the offending input was sampled. A sticky any-error flag rises with the first error pulse and is cleared only by reset.
- R10: After synchronous reset, all FIFOs are empty and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Observed request this cycle |
| req_id | input | 2 | Request transaction ID |
| req_tag | input | 8 | Request address tag |
| rsp_valid | input | 1 | Observed response this cycle |
| rsp_id | input | 2 | Response transaction ID |
| rsp_tag | input | 8 | Tag the response claims to complete |
| eot_start | input | 1 | End-of-test strobe |
| ord_err | output | 1 | Ordering-error pulse |
| ord_err_id | output | 2 | ID of the ordering error |
| orph_err | output | 1 | Orphan-response pulse |
| orph_err_id | output | 2 | ID of the orphan response |
| ovf_err | output | 1 | Overflow pulse |
| ovf_err_id | output | 2 | ID of the dropped request |
| any_err | output | 1 | Sticky error flag |
| rpt_valid | output | 1 | End-of-test report entry valid |
| rpt_id | output | 2 | ID being reported |
| rpt_count | output | 3 | Pending entries for that ID |
| eot_done | output | 1 | Report-finished pulse |
| eot_pass | output | 1 | All FIFOs were empty |

## Verification
Each error pulse and the sticky flag are due exactly one edge after the request or response that caused them. The bench drives every stimulus on a falling edge and samples on the next falling edge, after that single register stage. The end-of-test report places ID n on the output n+1 edges after the strobe is sampled, and done/pass one edge after the last ID. The bench counts edges to each of these points before sampling. Expected results come from a per-ID queue model in the bench, updated pop-before-push each step.

// File: rtl/idord_pkg.sv
package idord_pkg;
  localparam int unsigned DEF_IDS   = 4;
  localparam int unsigned DEF_DEPTH = 4;
  localparam int unsigned DEF_TAG_W = 8;

  typedef enum logic [1:0] {
    RPT_IDLE = 2'd0,
    RPT_WALK = 2'd1,
    RPT_FIN  = 2'd2
  } rpt_state_e;
endpackage

// File: rtl/id_tag_fifo.sv
module id_tag_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic [CW-1:0]    count
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  // storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_tag;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/eot_reporter.sv
module eot_reporter #(
  parameter int unsigned NUM_IDS = 4,
  parameter int unsigned CW      = 3,
  localparam int unsigned IW     = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NUM_IDS*CW-1:0] counts,
  output logic                  rpt_valid,
  output logic [IW-1:0]         rpt_id,
  output logic [CW-1:0]         rpt_count,
  output logic                  done,
  output logic                  pass
);
  import idord_pkg::*;
  localparam logic [IW-1:0] LAST = IW'(NUM_IDS - 1);

  rpt_state_e    st;
  logic [IW-1:0] idx;
  logic          ok;
  logic [CW-1:0] cur;

  assign cur = counts[idx*CW +: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RPT_IDLE;
      idx       <= '0;
      ok        <= 1'b0;
      rpt_valid <= 1'b0;
      rpt_id    <= '0;
      rpt_count <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
    end else begin
      rpt_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        RPT_IDLE: if (start) begin
          st   <= RPT_WALK;
          idx  <= '0;
          ok   <= 1'b1;
          pass <= 1'b0;
        end
        RPT_WALK: begin
          rpt_valid <= 1'b1;
          rpt_id    <= idx;
          rpt_count <= cur;
          ok        <= ok & (cur == '0);
          if (idx == LAST) st <= RPT_FIN;
          else             idx <= idx + 1'b1;
        end
        RPT_FIN: begin
          done <= 1'b1;
          pass <= ok;
          st   <= RPT_IDLE;
        end
        default: st <= RPT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/id_order_checker.sv
module id_order_checker #(
  parameter int unsigned NUM_IDS = idord_pkg::DEF_IDS,
  parameter int unsigned DEPTH   = idord_pkg::DEF_DEPTH,
  parameter int unsigned TAG_W   = idord_pkg::DEF_TAG_W,
  localparam int unsigned IW     = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IW-1:0]    req_id,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             rsp_valid,
  input  logic [IW-1:0]    rsp_id,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             eot_start,
  output logic             ord_err,
  output logic [IW-1:0]    ord_err_id,
  output logic             orph_err,
  output logic [IW-1:0]    orph_err_id,
  output logic             ovf_err,
  output logic [IW-1:0]    ovf_err_id,
  output logic             any_err,
  output logic             rpt_valid,
  output logic [IW-1:0]    rpt_id,
  output logic [CW-1:0]    rpt_count,
  output logic             eot_done,
  output logic             eot_pass
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [NUM_IDS*CW-1:0]    cnt_flat;
  logic [NUM_IDS*TAG_W-1:0] head_flat;
  logic [NUM_IDS-1:0]       pop_v, push_v;

  logic [CW-1:0]    rsp_cnt, req_cnt;
  logic [TAG_W-1:0] rsp_head;
  logic             rsp_hit, req_popped, req_full;
  logic             nxt_ord, nxt_orph, nxt_ovf;

  assign rsp_cnt    = cnt_flat[rsp_id*CW +: CW];
  assign req_cnt    = cnt_flat[req_id*CW +: CW];
  assign rsp_head   = head_flat[rsp_id*TAG_W +: TAG_W];
  assign rsp_hit    = rsp_valid && (rsp_cnt != '0);
  assign req_popped = rsp_hit && (rsp_id == req_id);
  assign req_full   = (req_cnt == FULL) && !req_popped;

  assign nxt_ord  = rsp_hit && (rsp_head != rsp_tag);
  assign nxt_orph = rsp_valid && (rsp_cnt == '0);
  assign nxt_ovf  = req_valid && req_full;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
    assign pop_v[g]  = rsp_hit && (rsp_id == IW'(g));
    assign push_v[g] = req_valid && (req_id == IW'(g)) && !req_full;

    id_tag_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (push_v[g]),
      .push_tag (req_tag),
      .pop      (pop_v[g]),
      .head     (head_flat[g*TAG_W +: TAG_W]),
      .count    (cnt_flat[g*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ord_err     <= 1'b0;
      orph_err    <= 1'b0;
      ovf_err     <= 1'b0;
      ord_err_id  <= '0;
      orph_err_id <= '0;
      ovf_err_id  <= '0;
      any_err     <= 1'b0;
    end else begin
      ord_err  <= nxt_ord;
      orph_err <= nxt_orph;
      ovf_err  <= nxt_ovf;
      if (nxt_ord)  ord_err_id  <= rsp_id;
      if (nxt_orph) orph_err_id <= rsp_id;
      if (nxt_ovf)  ovf_err_id  <= req_id;
      if (nxt_ord || nxt_orph || nxt_ovf) any_err <= 1'b1;
    end
  end

  eot_reporter #(.NUM_IDS(NUM_IDS), .CW(CW)) u_rpt (
    .clk       (clk),
    .rst       (rst),
    .start     (eot_start),
    .counts    (cnt_flat),
    .rpt_valid (rpt_valid),
    .rpt_id    (rpt_id),
    .rpt_count (rpt_count),
    .done      (eot_done),
    .pass      (eot_pass)
  );
endmodule

// File: rtl/id_order_checker_sva.sv
module id_order_checker_sva #(
  parameter int unsigned NUM_IDS = 4,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned CW      = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  rsp_valid,
  input logic                  ord_err,
  input logic                  orph_err,
  input logic                  ovf_err,
  input logic                  any_err,
  input logic                  rpt_valid,
  input logic                  eot_done,
  input logic [NUM_IDS*CW-1:0] cnt_flat
);
  // R2 R3: one response cannot be both an orphan and a mismatch
  a_r3_orphan_excl: assert property (@(posedge clk) disable iff (rst)
    !(ord_err && orph_err));

  // R3: an orphan pulse follows an observed response
  a_r3_orphan_cause: assert property (@(posedge clk) disable iff (rst)
    orph_err |-> $past(rsp_valid));

  // R5: an overflow pulse follows an observed request
  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> $past(req_valid));

  // R9: error pulses last one cycle unless a new cause arrives
  a_r9_ovf_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_err && !req_valid |=> !ovf_err);

  // R9: sticky flag never falls and accompanies every pulse
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    any_err |=> any_err);
  a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
    (ord_err || orph_err || ovf_err) |-> any_err);

  // R8: done is a pulse and never overlaps a report entry
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    eot_done |=> !eot_done);
  a_r8_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(eot_done && rpt_valid));

  // R5: no FIFO ever holds more than DEPTH tags
  for (genvar g = 0; g < NUM_IDS; g++) begin : g_bound
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[g*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind id_order_checker id_order_checker_sva #(
  .NUM_IDS(NUM_IDS), .DEPTH(DEPTH), .CW(CW)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .ord_err   (ord_err),
  .orph_err  (orph_err),
  .ovf_err   (ovf_err),
  .any_err   (any_err),
  .rpt_valid (rpt_valid),
  .eot_done  (eot_done),
  .cnt_flat  (cnt_flat)
);

// File: tb/sim_id_order_checker.sv
`timescale 1ns/1ps
module sim_id_order_checker;
  localparam int NI = 4;
  localparam int DP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 0, rsp_valid = 0, eot_start = 0;
  logic [1:0] req_id = 0, rsp_id = 0;
  logic [7:0] req_tag = 0, rsp_tag = 0;
  logic       ord_err, orph_err, ovf_err, any_err, rpt_valid, eot_done, eot_pass;
  logic [1:0] ord_err_id, orph_err_id, ovf_err_id, rpt_id;
  logic [2:0] rpt_count;

  always #2.5 clk = ~clk;

  id_order_checker u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  int mq [NI][DP];
  int mn [NI];
  bit m_any = 0;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // one stimulus cycle; model pops before pushing
  task automatic step(bit qv, int qi, int qt, bit sv, int si, int st, string rq);
    bit e_ord = 0, e_orph = 0, e_ovf = 0;
    req_valid = qv; req_id = qi[1:0]; req_tag = qt[7:0];
    rsp_valid = sv; rsp_id = si[1:0]; rsp_tag = st[7:0];
    if (sv) begin
      if (mn[si] == 0) e_orph = 1;
      else begin
        e_ord = (mq[si][0] != st);
        for (int k = 0; k < DP - 1; k++) mq[si][k] = mq[si][k+1];
        mn[si]--;
      end
    end
    if (qv) begin
      if (mn[qi] == DP) e_ovf = 1;
      else begin mq[qi][mn[qi]] = qt; mn[qi]++; end
    end
    m_any |= e_ord | e_orph | e_ovf;
    @(posedge clk); @(negedge clk);
    req_valid = 0; rsp_valid = 0;
    chk(ord_err == e_ord, {rq, " R2 ord_err"}, ord_err, e_ord);
    if (e_ord) chk(ord_err_id == si[1:0], {rq, " R2 ord_err_id"}, ord_err_id, si);
    chk(orph_err == e_orph, {rq, " R3 orph_err"}, orph_err, e_orph);
    if (e_orph) chk(orph_err_id == si[1:0], {rq, " R3 orph_err_id"}, orph_err_id, si);
    chk(ovf_err == e_ovf, {rq, " R5 ovf_err"}, ovf_err, e_ovf);
    if (e_ovf) chk(ovf_err_id == qi[1:0], {rq, " R5 ovf_err_id"}, ovf_err_id, qi);
    chk(any_err == m_any, {rq, " R9 any_err"}, any_err, m_any);
  endtask

  task automatic push(int i, int t, string rq); step(1, i, t, 0, 0, 0, rq); endtask
  task automatic resp(int i, int t, string rq); step(0, 0, 0, 1, i, t, rq); endtask

  task automatic eot_run();
    bit e_pass = 1;
    eot_start = 1;
    @(posedge clk); @(negedge clk);
    eot_start = 0;
    chk(rpt_valid == 0, "R7 no entry on strobe edge", rpt_valid, 0);
    for (int i = 0; i < NI; i++) begin
      if (i == 1) eot_start = 1;  // ignored while walking
      @(posedge clk); @(negedge clk);
      eot_start = 0;
      chk(rpt_valid == 1, "R7 rpt_valid", rpt_valid, 1);
      chk(rpt_id == i[1:0], "R7 rpt_id", rpt_id, i);
      chk(rpt_count == mn[i][2:0], "R7 rpt_count", rpt_count, mn[i]);
      if (mn[i] != 0) e_pass = 0;
    end
    @(posedge clk); @(negedge clk);
    chk(eot_done == 1, "R8 done pulse", eot_done, 1);
    chk(rpt_valid == 0, "R8 walk ended", rpt_valid, 0);
    chk(eot_pass == e_pass, "R8 pass", eot_pass, e_pass);
    @(posedge clk); @(negedge clk);
    chk(eot_done == 0, "R8 done one cycle", eot_done, 0);
    chk(eot_pass == e_pass, "R8 pass held", eot_pass, e_pass);
    chk(rpt_valid == 0, "R7 ignored strobe did not restart", rpt_valid, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < NI; i++) mn[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({ord_err, orph_err, ovf_err, any_err, rpt_valid, eot_done, eot_pass} == 7'b0,
        "R10 reset outputs", 0, 0);

    push(0, 8'h10, "R1"); push(0, 8'h11, "R1");
    resp(0, 8'h10, "R1"); resp(0, 8'h11, "R1");

    push(1, 8'h20, "R4"); push(2, 8'h30, "R4");
    resp(2, 8'h30, "R4 overtake"); resp(1, 8'h20, "R4");

    push(3, 8'h40, "R2"); push(3, 8'h41, "R2");
    resp(3, 8'h41, "R2 mismatch"); resp(3, 8'h41, "R2 head popped");

    resp(1, 8'h55, "R3 orphan");
    push(1, 8'h50, "R3"); resp(1, 8'h50, "R3 nothing popped");

    step(1, 0, 8'h60, 1, 0, 8'h60, "R6 same cycle empty");
    resp(0, 8'h60, "R6 push kept");

    for (int t = 0; t < DP; t++) push(2, 8'h70 + t, "R5 fill");
    push(2, 8'h74, "R5 full drop");
    step(1, 2, 8'h75, 1, 2, 8'h70, "R5 full with pop");
    resp(2, 8'h71, "R5"); resp(2, 8'h72, "R5");
    resp(2, 8'h73, "R5"); resp(2, 8'h75, "R5 dropped tag skipped");

    push(1, 8'h80, "R7"); push(3, 8'h81, "R7"); push(3, 8'h82, "R7");
    eot_run();

    for (int n = 0; n < 3000; n++) begin
      int qi, si, st;
      bit qv, sv;
      qv = ($urandom % 2) == 0;
      qi = $urandom % NI;
      sv = ($urandom % 2) == 0;
      si = $urandom % NI;
      st = (mn[si] > 0 && ($urandom % 8) != 0) ? mq[si][0] : int'($urandom % 256);
      step(qv, qi, $urandom % 256, sv, si, st, "R1 R4 random");
    end
    for (int i = 0; i < NI; i++)
      while (mn[i] > 0) resp(i, mq[i][0], "R1 drain");
    eot_run();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule